// File: doc/BRIEF.md
# Fixed-Latency Read Slave

This block is a memory-mapped read target with timing fixed at build time. A requester raises `cmd_valid` with an address. The block holds `cmd_ready` low for a set number of cycles before it takes the command. It then returns the word stored at that address a fixed number of cycles after the accepting cycle. Responses come back in the order the commands were taken. A counter limits how many taken reads may still be waiting for their data. Each of the three timing values is a parameter. A value outside its legal range (wait 0 to 1000, latency 0 to 63, outstanding limit 1 to 64) stops elaboration, and a limit of 0 is rejected.

The command side is a valid/ready handshake. A command transfers in a cycle where both `cmd_valid` and `cmd_ready` are high, and `cmd_addr` is sampled in that cycle. `cmd_ready` is driven from registered state only. The requester is expected to keep `cmd_valid` high until the transfer. If it drops `cmd_valid` early, the wait count starts again from zero. The response side has no back-pressure: `rsp_valid` pulses for exactly one cycle per accepted read, and the consumer must take the data in that cycle. The backing store is a small register array. Reset loads it with a fixed pattern, and it can only be read.

Top module: `flr_read_slave`

## Requirements
- R1: While reset is asserted, `rsp_valid` is 0 and `rsp_data` is 0, and no read is counted as outstanding once reset is released.
- R2: A command is accepted only after `cmd_valid` has been high with `cmd_ready` low for WAIT_CYC consecutive cycles, counted since the previous acceptance or since `cmd_valid` rose. With WAIT_CYC = 0, `cmd_ready` depends on the outstanding limit alone.
- R3: Dropping `cmd_valid` before acceptance resets the wait count to zero.
- R4: The word at address a is ((a × 0x0301) XOR 0x5A3C), truncated to DATA_W bits. This value is loaded into every address at reset.
- R5: For each acceptance, `rsp_valid` is high for exactly one cycle, RD_LAT cycles after the accepting cycle. With RD_LAT = 0, it is high in the accepting cycle itself.
- R6: Response data is the word at the accepted address, and responses come back in acceptance order.
- R7: A read counts as outstanding from the edge that ends its accepting cycle until the edge that ends its response cycle. `cmd_ready` is low whenever the outstanding count equals MAX_PEND.
- R8: `rsp_data` is 0 in every cycle where `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Read command present |
| cmd_ready | output | 1 | Command taken this cycle when `cmd_valid` is also high |
| cmd_addr | input | ADDR_W | Word address of the read |
| rsp_valid | output | 1 | Read data returned this cycle |
| rsp_data | output | DATA_W | Returned word, zero when not valid |

## Verification
The hardest state to reach from the ports is the outstanding limit. It only binds when the latency is long compared with the spacing between acceptances, and when the requester never lets go of `cmd_valid`. The bench therefore runs one instance with a short wait, a long latency and a limit of two, and holds `cmd_valid` high continuously for a long stretch so that acceptances stall on a full count. A second stretch toggles `cmd_valid` pseudo-randomly so that wait restarts occur. Two more instances cover the zero-latency path and a long wait.

// File: rtl/flr_pkg.sv
package flr_pkg;

  // Reset image of the backing store: (index * 0x0301) ^ 0x5A3C
  function automatic logic [63:0] flr_fill(input int unsigned idx);
    logic [63:0] prod;
    prod = 64'(idx) * 64'h0301;
    return prod ^ 64'h5A3C;
  endfunction

endpackage

// File: rtl/flr_store.sv
module flr_store #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_word
);
  import flr_pkg::*;

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  // Read-only array: preset at reset, held afterwards
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= DW'(flr_fill(i));
    end
  end

  assign rd_word = cells[rd_addr];

endmodule

// File: rtl/flr_gate.sv
module flr_gate #(
  parameter int WAIT_CYC = 1,
  parameter int MAX_PEND = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic rsp_fire,
  output logic cmd_ready,
  output logic take
);
  localparam int PW = $clog2(MAX_PEND + 1);
  localparam int WW = (WAIT_CYC > 0) ? $clog2(WAIT_CYC + 1) : 1;

  logic [PW-1:0] pend;
  logic          room;
  logic          wait_done;

  assign room      = pend < PW'(MAX_PEND);
  assign cmd_ready = wait_done && room;
  assign take      = cmd_valid && cmd_ready;

  generate
    if (WAIT_CYC == 0) begin : g_nowait
      assign wait_done = 1'b1;
    end else begin : g_wait
      logic [WW-1:0] wcnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  wcnt <= '0;
        else if (!cmd_valid || take) wcnt <= '0;
        else if (wcnt != WW'(WAIT_CYC)) wcnt <= wcnt + 1'b1;
      end

      assign wait_done = (wcnt == WW'(WAIT_CYC));

      // R3
      restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !cmd_ready);

      // R2
      post_take_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !cmd_ready);
    end
  endgenerate

  // Outstanding count: up on acceptance, down on return, both cancel
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pend <= '0;
    else if (take && !rsp_fire) pend <= pend + 1'b1;
    else if (!take && rsp_fire) pend <= pend - 1'b1;
  end

  // R7
  pend_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PW'(MAX_PEND));

  // R6
  no_orphan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire |-> (pend != '0) || take);

endmodule

// File: rtl/flr_pipe.sv
module flr_pipe #(
  parameter int LAT = 2,
  parameter int DW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  generate
    if (LAT == 0) begin : g_thru
      assign out_valid = in_valid;
      assign out_data  = in_valid ? in_data : '0;
    end else begin : g_shift
      logic [LAT-1:0] vld;
      logic [DW-1:0]  dat [LAT];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld <= '0;
          for (int k = 0; k < LAT; k++) dat[k] <= '0;
        end else begin
          vld[0] <= in_valid;
          dat[0] <= in_valid ? in_data : '0;
          for (int k = 1; k < LAT; k++) begin
            vld[k] <= vld[k-1];
            dat[k] <= dat[k-1];
          end
        end
      end

      assign out_valid = vld[LAT-1];
      assign out_data  = dat[LAT-1];
    end
  endgenerate

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0));

endmodule

// File: rtl/flr_read_slave.sv
module flr_read_slave #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16,
  parameter int WAIT_CYC = 1,
  parameter int RD_LAT   = 2,
  parameter int MAX_PEND = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  generate
    if (MAX_PEND < 1 || MAX_PEND > 64) begin : g_bad_pend
      $error("flr_read_slave: MAX_PEND must lie in 1..64");
    end
    if (RD_LAT < 0 || RD_LAT > 63) begin : g_bad_lat
      $error("flr_read_slave: RD_LAT must lie in 0..63");
    end
    if (WAIT_CYC < 0 || WAIT_CYC > 1000) begin : g_bad_wait
      $error("flr_read_slave: WAIT_CYC must lie in 0..1000");
    end
  endgenerate

  logic              take;
  logic [DATA_W-1:0] rd_word;

  flr_gate #(
    .WAIT_CYC (WAIT_CYC),
    .MAX_PEND (MAX_PEND)
  ) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .rsp_fire  (rsp_valid),
    .cmd_ready (cmd_ready),
    .take      (take)
  );

  flr_store #(
    .AW (ADDR_W),
    .DW (DATA_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (cmd_addr),
    .rd_word (rd_word)
  );

  flr_pipe #(
    .LAT (RD_LAT),
    .DW  (DATA_W)
  ) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (take),
    .in_data   (rd_word),
    .out_valid (rsp_valid),
    .out_data  (rsp_data)
  );

  generate
    if (RD_LAT == 0) begin : g_zero_lat_chk
      // R5
      same_cycle_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> rsp_valid);
    end
  endgenerate

endmodule

// File: tb/flr_read_slave_tb.sv
module flr_tb_ref #(
  parameter int    AW   = 4,
  parameter int    DW   = 16,
  parameter int    WAIT = 1,
  parameter int    LAT  = 2,
  parameter int    MAXP = 1,
  parameter string NAME = "x"
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [AW-1:0] addr,
  input  logic          dut_ready,
  input  logic          dut_rvalid,
  input  logic [DW-1:0] dut_rdata,
  output int            n_cmp,
  output int            n_bad
);
  int cmp_cnt = 0;
  int bad_cnt = 0;
  int waited = 0;
  int outst = 0;
  int cyc = 0;
  int due_q[$];
  logic [DW-1:0] dat_q[$];

  assign n_cmp = cmp_cnt;
  assign n_bad = bad_cnt;

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    logic [31:0] w;
    w = (32'(a) * 32'h0301) ^ 32'h5A3C;  // R4
    return DW'(w);
  endfunction

  always @(negedge clk) begin
    logic e_rdy;
    logic e_v;
    logic acc;
    logic [DW-1:0] e_d;
    if (!rst_n) begin
      waited = 0; outst = 0; cyc = 0;
      due_q.delete(); dat_q.delete();
    end else begin
      e_rdy = (waited >= WAIT) && (outst < MAXP);
      acc   = cmd_valid && e_rdy;
      e_v   = 1'b0;
      e_d   = '0;
      if (due_q.size() > 0 && due_q[0] == cyc) begin
        e_v = 1'b1;
        e_d = dat_q[0];
        void'(due_q.pop_front());
        void'(dat_q.pop_front());
      end else if (LAT == 0 && acc) begin
        e_v = 1'b1;
        e_d = word_of(addr);
      end
      cmp_cnt++;
      if (dut_ready !== e_rdy) begin
        bad_cnt++;
        $display("FAIL %s R2 R3 R7 cmd_ready actual=%0b expected=%0b cyc=%0d", NAME, dut_ready, e_rdy, cyc);
      end
      cmp_cnt++;
      if (dut_rvalid !== e_v) begin
        bad_cnt++;
        $display("FAIL %s R5 rsp_valid actual=%0b expected=%0b cyc=%0d", NAME, dut_rvalid, e_v, cyc);
      end
      cmp_cnt++;
      if (dut_rdata !== e_d) begin
        bad_cnt++;
        if (e_v)
          $display("FAIL %s R4 R6 rsp_data actual=%h expected=%h cyc=%0d", NAME, dut_rdata, e_d, cyc);
        else
          $display("FAIL %s R8 idle rsp_data actual=%h expected=%h cyc=%0d", NAME, dut_rdata, e_d, cyc);
      end
      if (acc && LAT > 0) begin
        due_q.push_back(cyc + LAT);
        dat_q.push_back(word_of(addr));
      end
      if (e_v) outst--;
      if (acc) outst++;
      if (!cmd_valid || acc) waited = 0;
      else if (waited < WAIT) waited++;
      cyc++;
    end
  end
endmodule

module flr_read_slave_tb;
  localparam int AW = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [15:0]   lfsr = 16'hACE1;
  logic          done = 1'b0;
  int            own_cmp = 0;
  int            own_bad = 0;

  always #5 clk = ~clk;

  logic rdy_a, rv_a, rdy_b, rv_b, rdy_c, rv_c;
  logic [DW-1:0] rd_a, rd_b, rd_c;
  int c_a, b_a, c_b, b_b, c_c, b_c;

  // Instance A: long latency against short wait, limit of two (R7)
  flr_read_slave #(.ADDR_W(AW), .DATA_W(DW), .WAIT_CYC(1), .RD_LAT(5), .MAX_PEND(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy_a),
    .cmd_addr(cmd_addr), .rsp_valid(rv_a), .rsp_data(rd_a));
  flr_tb_ref #(.AW(AW), .DW(DW), .WAIT(1), .LAT(5), .MAXP(2), .NAME("A")) u_ref_a (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .addr(cmd_addr),
    .dut_ready(rdy_a), .dut_rvalid(rv_a), .dut_rdata(rd_a), .n_cmp(c_a), .n_bad(b_a));

  // Instance B: no wait, zero latency (R5 same-cycle return)
  flr_read_slave #(.ADDR_W(AW), .DATA_W(DW), .WAIT_CYC(0), .RD_LAT(0), .MAX_PEND(1)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy_b),
    .cmd_addr(cmd_addr), .rsp_valid(rv_b), .rsp_data(rd_b));
  flr_tb_ref #(.AW(AW), .DW(DW), .WAIT(0), .LAT(0), .MAXP(1), .NAME("B")) u_ref_b (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .addr(cmd_addr),
    .dut_ready(rdy_b), .dut_rvalid(rv_b), .dut_rdata(rd_b), .n_cmp(c_b), .n_bad(b_b));

  // Instance C: long wait, so early drops of cmd_valid restart it (R3)
  flr_read_slave #(.ADDR_W(AW), .DATA_W(DW), .WAIT_CYC(3), .RD_LAT(1), .MAX_PEND(1)) u_dut_c (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy_c),
    .cmd_addr(cmd_addr), .rsp_valid(rv_c), .rsp_data(rd_c));
  flr_tb_ref #(.AW(AW), .DW(DW), .WAIT(3), .LAT(1), .MAXP(1), .NAME("C")) u_ref_c (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .addr(cmd_addr),
    .dut_ready(rdy_c), .dut_rvalid(rv_c), .dut_rdata(rd_c), .n_cmp(c_c), .n_bad(b_c));

  task automatic summary();
    int tc;
    int tb;
    tc = own_cmp + c_a + c_b + c_c;
    tb = own_bad + b_a + b_b + b_c;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", tc, tb);
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // R1: reset state seen at the response ports
  task automatic check_reset();
    own_cmp++;
    if (rv_a !== 1'b0 || rv_b !== 1'b0 || rv_c !== 1'b0) begin
      own_bad++;
      $display("FAIL R1 rsp_valid in reset actual=%0b%0b%0b expected=000", rv_a, rv_b, rv_c);
    end
    own_cmp++;
    if (rd_a !== '0 || rd_b !== '0 || rd_c !== '0) begin
      own_bad++;
      $display("FAIL R1 rsp_data in reset actual=%h/%h/%h expected=0", rd_a, rd_b, rd_c);
    end
  endtask

  initial begin
    repeat (4) begin
      @(negedge clk);
      check_reset();
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    // Continuous requests: fills the outstanding count (R7, R5, R6)
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #1;
      step_lfsr();
      cmd_valid = 1'b1;
      cmd_addr  = lfsr[AW-1:0];
    end
    // Sporadic requests with early drops: wait restarts (R3, R2)
    for (int i = 0; i < 600; i++) begin
      @(posedge clk); #1;
      step_lfsr();
      cmd_valid = (lfsr[2:0] != 3'b000);
      cmd_addr  = lfsr[AW+3:4];
    end
    // Drain: idle responses must be zero (R8)
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      cmd_valid = 1'b0;
    end
    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      own_cmp++;
      own_bad++;
      $display("FAIL R5 watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule